// File: doc/BRIEF.md
# Quadword Bit-Field Extract Unit

This unit takes a contiguous run of bits out of the lower 64 bits of a 128-bit operand. It shifts the run down to bit 0 and zero-fills the rest of the low quadword. The run is described by a 6-bit start position and a 6-bit length. Both come either from two 8-bit immediate bytes or from fixed bit ranges of a second 128-bit operand, and a mode input selects the source. A length code of zero stands for a full 64-bit run.

The result appears one clock after the request is accepted. It is held under a valid/ready handshake until the consumer takes it. Some position/length combinations give an architecturally undefined result. For these the unit raises a status flag and still produces a deterministic value. The upper quadword of the result passes the upper quadword of the first operand through unchanged.

Top module: `qfx_unit`

## Requirements
- R1: The low 64 bits of `out_data` equal `in_src[63:0]` shifted right by the start position, with every bit at or above the effective length cleared. Bits of `in_src` above bit 63 never reach the low quadword.
- R2: A length code of 0 means an effective length of 64. With length code 0 and start 0, `out_data[63:0]` equals `in_src[63:0]` and `out_undef` is 0.
- R3: When `in_mode` is 1 (operand mode), the length code is `in_ctl[5:0]` and the start position is `in_ctl[13:8]`. All other bits of `in_ctl` have no effect on the result.
- R4: When `in_mode` is 0 (immediate mode), the length code is `in_imm_len[5:0]` and the start position is `in_imm_idx[5:0]`. Bits 7:6 of both bytes have no effect.
- R5: `out_undef` is 1 exactly when the start position plus the effective length exceeds 64. This includes length code 0 with a nonzero start. In that case the low quadword still holds the shifted and masked value, with the field cut off at source bit 63.
- R6: `out_data[127:64]` equals `in_src[127:64]` of the accepted request.
- R7: A request is accepted on a rising edge where `in_valid` and `in_ready` are both 1. From the next cycle `out_valid` is 1 and the outputs carry that request's result.
- R8: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_undef` hold steady. A result is dropped from the output only when `out_ready` is 1.
- R9: While `rst_n` is 0 (active low, synchronous), `out_valid`, `out_undef` and `out_data` are cleared to 0.
- R10: With start 32 and length 16, `out_data[15:0]` equals `in_src[47:32]` and `out_data[63:16]` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_mode | input | 1 | 0: immediates give length/start, 1: `in_ctl` gives them |
| in_src | input | 128 | Operand holding the source quadword |
| in_ctl | input | 128 | Control operand used in operand mode |
| in_imm_len | input | 8 | Length byte for immediate mode |
| in_imm_idx | input | 8 | Start byte for immediate mode |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Extracted field in low quadword, passthrough in high |
| out_undef | output | 1 | Start plus length exceeded the quadword |

## Verification
The hardest situation to reach is a stalled result that must stay frozen. The consumer withholds `out_ready` while a new, different request is waiting on the input. A wrong ready path or an unguarded register would then quietly overwrite the result. The bench produces this case directly, holding a changed request on the inputs for several cycles with `out_ready` low before draining. A long random phase mixes both modes, undefined spans and random back-pressure. Directed cases pin the exact boundary where start plus length equals 64, which is still defined.

// File: rtl/qfx_pkg.sv
package qfx_pkg;

    localparam int QW_DEF    = 64;
    localparam int IMM_W_DEF = 8;

    typedef enum logic {
        SRC_IMM = 1'b0,
        SRC_OPD = 1'b1
    } qfx_src_e;

endpackage

// File: rtl/qfx_field_sel.sv
module qfx_field_sel #(
    parameter int QW      = qfx_pkg::QW_DEF,
    parameter int IMM_W   = qfx_pkg::IMM_W_DEF,
    parameter int LEN_LSB = 0,
    parameter int IDX_LSB = 8,
    localparam int POS_W  = $clog2(QW)
) (
    input  logic              mode,
    input  logic [QW-1:0]     ctl_lo,
    input  logic [IMM_W-1:0]  imm_len,
    input  logic [IMM_W-1:0]  imm_idx,
    output logic [POS_W-1:0]  len_code,
    output logic [POS_W-1:0]  start
);
    import qfx_pkg::*;

    logic [POS_W-1:0] opd_len;
    logic [POS_W-1:0] opd_idx;

    // Only the low POS_W bits of each carrier matter; the rest are ignored.
    assign opd_len = ctl_lo[LEN_LSB +: POS_W];
    assign opd_idx = ctl_lo[IDX_LSB +: POS_W];

    always_comb begin
        if (qfx_src_e'(mode) == SRC_OPD) begin
            len_code = opd_len;
            start    = opd_idx;
        end else begin
            len_code = imm_len[POS_W-1:0];
            start    = imm_idx[POS_W-1:0];
        end
    end

endmodule

// File: rtl/qfx_extract.sv
module qfx_extract #(
    parameter int QW     = qfx_pkg::QW_DEF,
    localparam int POS_W = $clog2(QW),
    localparam int CNT_W = POS_W + 1
) (
    input  logic [QW-1:0]    src_lo,
    input  logic [POS_W-1:0] len_code,
    input  logic [POS_W-1:0] start,
    output logic [QW-1:0]    field,
    output logic             undef
);
    localparam logic [CNT_W-1:0] QW_C = CNT_W'(QW);

    logic [CNT_W-1:0] eff_len;
    logic [CNT_W-1:0] mask_sh;
    logic [CNT_W-1:0] span;
    logic [QW-1:0]    shifted;
    logic [QW-1:0]    mask;

    // Length code zero selects the whole quadword.
    assign eff_len = (len_code == '0) ? QW_C : {1'b0, len_code};

    // Mask is narrowed from all-ones so no shift ever reaches QW.
    assign mask_sh = QW_C - eff_len;
    assign mask    = {QW{1'b1}} >> mask_sh;
    assign shifted = src_lo >> start;
    assign field   = shifted & mask;

    assign span  = {1'b0, start} + eff_len;
    assign undef = (span > QW_C);

endmodule

// File: rtl/qfx_unit.sv
module qfx_unit #(
    parameter int QW      = qfx_pkg::QW_DEF,
    parameter int IMM_W   = qfx_pkg::IMM_W_DEF,
    parameter int LEN_LSB = 0,
    parameter int IDX_LSB = 8,
    localparam int FULL_W = 2 * QW,
    localparam int POS_W  = $clog2(QW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_mode,
    input  logic [FULL_W-1:0] in_src,
    input  logic [FULL_W-1:0] in_ctl,
    input  logic [IMM_W-1:0]  in_imm_len,
    input  logic [IMM_W-1:0]  in_imm_idx,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [FULL_W-1:0] out_data,
    output logic              out_undef
);

    typedef struct packed {
        logic              valid;
        logic              undef;
        logic [FULL_W-1:0] data;
    } state_t;

    state_t state_d;
    state_t state_q;

    logic [POS_W-1:0] len_code;
    logic [POS_W-1:0] start;
    logic [QW-1:0]    field;
    logic             span_bad;
    logic             accept;
    logic [QW-1:0]    ctl_hi_unused;

    assign ctl_hi_unused = in_ctl[FULL_W-1:QW];

    qfx_field_sel #(
        .QW      (QW),
        .IMM_W   (IMM_W),
        .LEN_LSB (LEN_LSB),
        .IDX_LSB (IDX_LSB)
    ) u_sel (
        .mode     (in_mode),
        .ctl_lo   (in_ctl[QW-1:0]),
        .imm_len  (in_imm_len),
        .imm_idx  (in_imm_idx),
        .len_code (len_code),
        .start    (start)
    );

    qfx_extract #(
        .QW (QW)
    ) u_ext (
        .src_lo   (in_src[QW-1:0]),
        .len_code (len_code),
        .start    (start),
        .field    (field),
        .undef    (span_bad)
    );

    assign in_ready = !state_q.valid || out_ready;
    assign accept   = in_valid && in_ready;

    always_comb begin
        state_d = state_q;
        if (accept) begin
            state_d.valid = 1'b1;
            state_d.undef = span_bad;
            state_d.data  = {in_src[FULL_W-1:QW], field};
        end else if (out_ready) begin
            state_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.valid;
    assign out_undef = state_q.undef;
    assign out_data  = state_q.data;

endmodule

// File: rtl/qfx_unit_chk.sv
module qfx_unit_chk #(
    parameter int QW      = qfx_pkg::QW_DEF,
    parameter int IMM_W   = qfx_pkg::IMM_W_DEF,
    localparam int FULL_W = 2 * QW,
    localparam int POS_W  = $clog2(QW)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_mode,
    input logic [FULL_W-1:0] in_src,
    input logic [IMM_W-1:0]  in_imm_len,
    input logic [IMM_W-1:0]  in_imm_idx,
    input logic              out_valid,
    input logic              out_ready,
    input logic [FULL_W-1:0] out_data,
    input logic              out_undef
);

    // R7
    accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_undef)));

    // R8
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);

    // R6
    upper_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_data[FULL_W-1:QW] == $past(in_src[FULL_W-1:QW])));

    // R2
    full_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_mode && in_imm_len[POS_W-1:0] == '0
         && in_imm_idx[POS_W-1:0] == '0)
        |=> (out_data[QW-1:0] == $past(in_src[QW-1:0]) && !out_undef));

    // R5
    len0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_mode && in_imm_len[POS_W-1:0] == '0
         && in_imm_idx[POS_W-1:0] != '0)
        |=> out_undef);

endmodule

bind qfx_unit qfx_unit_chk #(.QW(QW), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/qfx_unit_bench.sv
`timescale 1ns/1ps
module qfx_unit_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         in_mode = 1'b0;
    logic [127:0] in_src = '0;
    logic [127:0] in_ctl = '0;
    logic [7:0]   in_imm_len = '0;
    logic [7:0]   in_imm_idx = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [127:0] out_data;
    logic         out_undef;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    logic         m_valid = 1'b0;
    logic [127:0] m_data  = '0;
    logic         m_undef = 1'b0;

    always #2.5 clk = ~clk;

    qfx_unit u_qfx_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_mode    (in_mode),
        .in_src     (in_src),
        .in_ctl     (in_ctl),
        .in_imm_len (in_imm_len),
        .in_imm_idx (in_imm_idx),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .out_undef  (out_undef)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bit-by-bit behavioural model of the extract.
    function automatic void model(input logic [63:0] src, input int len, input int idx,
                                  output logic [63:0] f, output logic u);
        int eff;
        eff = (len == 0) ? 64 : len;
        f = '0;
        for (int b = 0; b < eff; b++) begin
            if (idx + b < 64) f[b] = src[idx + b];
        end
        u = (idx + eff) > 64;
    endfunction

    task automatic step(input logic v, input logic md, input logic [127:0] s,
                        input logic [127:0] c, input logic [7:0] il, input logic [7:0] ii,
                        input logic rdy, input string tag);
        logic        acc;
        logic [63:0] f;
        logic        u;
        int          len;
        int          idx;
        in_valid = v; in_mode = md; in_src = s; in_ctl = c;
        in_imm_len = il; in_imm_idx = ii; out_ready = rdy;
        #1;
        check("R8 in_ready", {127'b0, in_ready}, {127'b0, (!m_valid || rdy)});
        acc = v && (!m_valid || rdy);
        if (md) begin len = int'(c[5:0]); idx = int'(c[13:8]); end
        else    begin len = int'(il[5:0]); idx = int'(ii[5:0]); end
        model(s[63:0], len, idx, f, u);
        @(posedge clk);
        @(negedge clk);
        if (acc) begin
            m_valid = 1'b1; m_data = {s[127:64], f}; m_undef = u;
        end else if (rdy) begin
            m_valid = 1'b0;
        end
        check({tag, " R7 out_valid"}, {127'b0, out_valid}, {127'b0, m_valid});
        if (m_valid) begin
            check({tag, " R6 data"}, out_data, m_data);
            check({tag, " R5 undef"}, {127'b0, out_undef}, {127'b0, m_undef});
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [127:0] a;
        logic [127:0] b;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 out_valid", {127'b0, out_valid}, '0);
        check("R9 out_data", out_data, '0);
        check("R9 out_undef", {127'b0, out_undef}, '0);
        rst_n = 1'b1;

        a = 128'hfedc_ba98_7654_3210_0123_4567_89ab_cdef;
        // R10 worked example: start 32, length 16
        step(1, 0, a, '0, 8'd16, 8'd32, 1, "R10");
        check("R10 low", {64'b0, out_data[63:0]}, {112'b0, a[47:32]});
        // R2 full length
        step(1, 0, a, '0, 8'd0, 8'd0, 1, "R2");
        check("R2 full", {64'b0, out_data[63:0]}, {64'b0, a[63:0]});
        // R3 operand mode with junk in other control bits
        step(1, 1, a, {112'hffff_ffff_ffff_ffff_ffff_ffff_ffff, 2'b11, 6'd4, 2'b11, 6'd12},
             8'hff, 8'hff, 1, "R3");
        check("R3 field", {64'b0, out_data[63:0]}, {116'b0, a[15:4]});
        // R4 immediate mode with bits 7:6 set
        step(1, 0, a, rnd128(), 8'hc8, 8'h48, 1, "R4");
        check("R4 field", {64'b0, out_data[63:0]}, {120'b0, a[15:8]});
        // R5 undefined spans and the defined boundary
        step(1, 0, a, '0, 8'd0, 8'd5, 1, "R5 len0");
        check("R5 len0 flag", {127'b0, out_undef}, {127'b0, 1'b1});
        step(1, 0, a, '0, 8'd8, 8'd60, 1, "R5 over");
        check("R5 over field", {64'b0, out_data[63:0]}, {124'b0, a[63:60]});
        step(1, 1, a, {114'b0, 6'd48, 2'b0, 6'd16}, 8'd0, 8'd0, 1, "R5 edge");
        check("R5 edge flag", {127'b0, out_undef}, '0);
        // R1 upper source bits must not leak
        step(1, 0, {64'hffff_ffff_ffff_ffff, 64'h0}, '0, 8'd1, 8'd63, 1, "R1");
        check("R1 no leak", {64'b0, out_data[63:0]}, '0);
        // R8 stall with a different request waiting
        b = rnd128();
        step(1, 0, a, '0, 8'd20, 8'd3, 1, "R8 load");
        for (int k = 0; k < 4; k++) step(1, 1, b, b, 8'd5, 8'd5, 0, "R8 stall");
        step(0, 0, b, b, 8'd5, 8'd5, 1, "R8 drain");
        step(0, 0, b, b, 8'd5, 8'd5, 1, "R8 idle");
        // R1 random traffic in both modes with back-pressure
        for (int k = 0; k < 400; k++) begin
            step(1'($urandom), 1'($urandom), rnd128(), rnd128(), 8'($urandom),
                 8'($urandom), ($urandom % 4) != 0, "R1 rand");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule